// File: doc/BRIEF.md
# Register-Mapped Reset Line Controller

This block drives a bank of peripheral reset outputs (64 by default) from a simple 32-bit register bus. Software asserts a reset by writing 1 to that line's bit in one of the control words. Almost every line is pulsed: once asserted, it stays active for a fixed number of clock cycles and then releases by itself. Two lines are level-held. They stay asserted until software writes 0 to their bits, and they come out of block reset already asserted, so the subsystems they feed stay parked until software releases them.

Line 0 is the system-core reset and also drives a dedicated system-reset output. Status words report each line with inverted polarity. Software can therefore read a status word, invert it, OR in the bit it wants and write the result back. Lines that are already active are not disturbed by this, and the held lines keep their state.

Top module: `rgu_top`

## Requirements
- R1: Line n is controlled by control word n/32 at offset 0x100 + 4*(n/32), bit n%32. Word 0 (0x100) holds lines 0 to 31 and word 1 (0x104) holds lines 32 to 63. Line n drives `rst_out[n]`.
- R2: A bus write with bit b set in a control word activates the matching inactive line. `rst_out` shows the line as active on the first cycle after the write is sampled.
- R3: A pulsed line stays active for exactly PULSE_LEN cycles (16 by default) and then releases without any further write.
- R4: Writing 0 to the bit of a pulsed line has no effect. An active pulse keeps running and an idle line stays idle.
- R5: Writing 1 to a pulsed line that is already active neither restarts nor extends its pulse. It still releases PULSE_LEN cycles after its first activation.
- R6: Lines 12 and 56 are held lines. Writing 1 sets them and writing 0 clears them, and they keep their state for any length of time without a write.
- R7: Status words at 0x150 (lines 0 to 31) and 0x154 (lines 32 to 63) use the R1 bit mapping with active-low polarity: a bit reads 0 while its line is active and 1 while it is inactive.
- R8: A read of a control word returns the current line state, with 1 meaning active. Read data appears on `rdata` the cycle after `rd_en` and is zero in every other cycle.
- R9: `sys_rst_out` is high exactly while line 0 is active. Line 0 is a pulsed line.
- R10: After the synchronous block reset, lines 12 and 56 are active and all other lines, including `sys_rst_out`, are inactive.
- R11: Writes to any offset other than the two control words change nothing, including writes to status words and to misaligned offsets. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en, zero otherwise |
| rst_out | output | 64 | Reset lines, 1 = reset active |
| sys_rst_out | output | 1 | System-core reset, mirrors line 0 |

## Verification
A control write is sampled on one rising edge. Its effect is due on `rst_out` on the falling edge right after that edge. A pulsed line must still read active PULSE_LEN-1 falling edges later and must read inactive on the next one. For the no-restart case, the release time is counted from the first write, not from the repeated one. Read results are due one cycle after the strobe. The monitor records `rd_en` at the rising edge and compares `rdata` 1 ns later against the value the driver queued.

// File: rtl/rgu_pkg.sv
package rgu_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_CTRL = 2'd1,
    RSEL_STAT = 2'd2
  } rsel_e;

  function automatic bit line_is_held(input int idx, input int held_a, input int held_b);
    return (idx == held_a) || (idx == held_b);
  endfunction

endpackage

// File: rtl/rgu_decode.sv
module rgu_decode
  import rgu_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_REGS  = 2,
  parameter int CTRL_BASE = 'h100,
  parameter int STAT_BASE = 'h150,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] wr_hit,
  output rsel_e               rd_sel,
  output logic [IDX_W-1:0]    rd_idx
);

  logic [NUM_REGS-1:0] ctrl_match;
  logic [NUM_REGS-1:0] stat_match;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_match
    assign ctrl_match[r] = (addr == ADDR_W'(CTRL_BASE + 4 * r));
    assign stat_match[r] = (addr == ADDR_W'(STAT_BASE + 4 * r));
  end

  // Only the control words accept writes; everything else is dropped here.
  assign wr_hit = wr_en ? ctrl_match : '0;

  always_comb begin
    rd_sel = RSEL_NONE;
    rd_idx = '0;
    if (rd_en) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (ctrl_match[r]) begin
          rd_sel = RSEL_CTRL;
          rd_idx = IDX_W'(r);
        end
        if (stat_match[r]) begin
          rd_sel = RSEL_STAT;
          rd_idx = IDX_W'(r);
        end
      end
    end
  end

endmodule

// File: rtl/rgu_line.sv
module rgu_line #(
  parameter int PULSE_LEN = 16,
  parameter bit HELD      = 1'b0,
  localparam int CNT_W    = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic active
);

  if (HELD) begin : g_held
    // Level-held line: follows the written bit, comes up asserted.
    always_ff @(posedge clk) begin
      if (rst)         active <= 1'b1;
      else if (wr_stb) active <= wr_bit;
    end

    AST_HELD_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (active && !wr_stb) |=> active);  // R6
    AST_HELD_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && !wr_bit) |=> !active);  // R6

  end else begin : g_pulse
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
      if (rst) begin
        active <= 1'b0;
        remain <= '0;
      end else if (!active) begin
        if (wr_stb && wr_bit) begin
          active <= 1'b1;
          remain <= CNT_W'(PULSE_LEN - 1);
        end
      end else if (remain == '0) begin
        active <= 1'b0;
      end else begin
        remain <= remain - 1'b1;
      end
    end

    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (rst)
      (active && remain == '0) |=> !active);  // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
      (active && remain != '0) |=> (active && remain == $past(remain) - 1'b1));  // R5
    AST_ZERO_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (!active && !(wr_stb && wr_bit)) |=> !active);  // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      remain <= CNT_W'(PULSE_LEN - 1));  // R3
  end

endmodule

// File: rtl/rgu_readback.sv
module rgu_readback
  import rgu_pkg::*;
#(
  parameter int NUM_REGS  = 2,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int NUM_LINES = NUM_REGS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rsel_e                rd_sel,
  input  logic [IDX_W-1:0]     rd_idx,
  input  logic [NUM_LINES-1:0] line_act,
  output logic [WORD_W-1:0]    rdata
);

  logic [WORD_W-1:0] words [NUM_REGS];
  logic [WORD_W-1:0] picked;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_words
    assign words[r] = line_act[r*WORD_W +: WORD_W];
  end

  always_comb begin
    picked = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rd_idx == IDX_W'(r)) picked = words[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (rd_sel)
        RSEL_CTRL: rdata <= picked;
        RSEL_STAT: rdata <= ~picked;
        default:   rdata <= '0;
      endcase
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == RSEL_NONE) |=> (rdata == '0));  // R11

endmodule

// File: rtl/rgu_top.sv
module rgu_top
  import rgu_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_REGS  = 2,
  parameter int PULSE_LEN = 16,
  parameter int HELD_A    = 12,
  parameter int HELD_B    = 56,
  parameter int CTRL_BASE = 'h100,
  parameter int STAT_BASE = 'h150,
  localparam int NUM_LINES = NUM_REGS * WORD_W,
  localparam int IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  output logic [NUM_LINES-1:0] rst_out,
  output logic                 sys_rst_out
);

  logic [NUM_REGS-1:0]  wr_hit;
  rsel_e                rd_sel;
  logic [IDX_W-1:0]     rd_idx;
  logic [NUM_LINES-1:0] line_act;

  rgu_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_REGS  (NUM_REGS),
    .CTRL_BASE (CTRL_BASE),
    .STAT_BASE (STAT_BASE)
  ) u_decode (
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wr_hit (wr_hit),
    .rd_sel (rd_sel),
    .rd_idx (rd_idx)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    rgu_line #(
      .PULSE_LEN (PULSE_LEN),
      .HELD      (line_is_held(n, HELD_A, HELD_B))
    ) u_line (
      .clk    (clk),
      .rst    (rst),
      .wr_stb (wr_hit[n / WORD_W]),
      .wr_bit (wdata[n % WORD_W]),
      .active (line_act[n])
    );
  end

  rgu_readback #(
    .NUM_REGS (NUM_REGS)
  ) u_readback (
    .clk      (clk),
    .rst      (rst),
    .rd_sel   (rd_sel),
    .rd_idx   (rd_idx),
    .line_act (line_act),
    .rdata    (rdata)
  );

  assign rst_out     = line_act;
  assign sys_rst_out = line_act[0];

  AST_HELD_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rst_out[HELD_A] && rst_out[HELD_B] && !sys_rst_out));  // R10
  AST_SYS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(CTRL_BASE) && wdata[0]) |=> sys_rst_out);  // R9
  AST_STAT_ACTIVE_LOW: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(STAT_BASE)) |=> (rdata == ~$past(rst_out[WORD_W-1:0])));  // R7
  AST_CTRL_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(CTRL_BASE)) |=> (rdata == $past(rst_out[WORD_W-1:0])));  // R8
  AST_STAT_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(STAT_BASE) && !rst_out[1]) |=> !rst_out[1]);  // R11

endmodule

// File: tb/tb_rgu_top.sv
`timescale 1ns/1ps
module tb_rgu_top;

  localparam int PL = 16;
  localparam logic [11:0] CTRL0 = 12'h100;
  localparam logic [11:0] CTRL1 = 12'h104;
  localparam logic [11:0] STAT0 = 12'h150;
  localparam logic [11:0] STAT1 = 12'h154;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] rst_out;
  logic        sys_rst_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #2 clk = ~clk;

  rgu_top #(.PULSE_LEN(PL)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_out(rst_out), .sys_rst_out(sys_rst_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Caller stands at a falling edge; returns at the falling edge after the sampling edge.
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string req);
    rd_item_t it;
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pops the expected read data one cycle after each strobe.
  always @(posedge clk) begin
    bit was_rd;
    rd_item_t it;
    was_rd = rd_en;
    #1;
    if (was_rd) begin
      if (sb_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: read result with no expected entry");
      end else begin
        it = sb_q.pop_front();
        check(it.req, {32'h0, rdata}, {32'h0, it.exp});
      end
    end else begin
      if (!rst && rdata !== 32'h0) begin
        total++; bad++;
        $display("FAIL R8: actual=%h expected=00000000 outside a read", rdata);
      end
    end
  end

  initial begin
    logic [63:0] snap;
    idle(4);
    rst = 1'b0;
    @(negedge clk);

    // R10: reset state
    check("R10 reset lines", rst_out, 64'h0100_0000_0000_1000);
    check("R10 sys reset idle", {63'h0, sys_rst_out}, 64'h0);
    bus_read(CTRL0, 32'h0000_1000, "R8 ctrl0 after reset");
    bus_read(CTRL1, 32'h0100_0000, "R1 ctrl1 holds line 56");
    bus_read(STAT0, 32'hFFFF_EFFF, "R7 stat0 active-low");
    bus_read(STAT1, 32'hFEFF_FFFF, "R7 stat1 active-low");

    // R2 / R3: pulse on line 3
    bus_write(CTRL0, 32'h0000_1008);
    check("R2 line 3 asserted", {63'h0, rst_out[3]}, 64'h1);
    idle(PL - 1);
    check("R3 line 3 still active at last cycle", {63'h0, rst_out[3]}, 64'h1);
    idle(1);
    check("R3 line 3 released", {63'h0, rst_out[3]}, 64'h0);
    check("R6 line 12 kept by write of 1", {63'h0, rst_out[12]}, 64'h1);

    // R4: writing 0 leaves a running pulse alone
    bus_write(CTRL0, 32'h0000_1080);
    bus_write(CTRL0, 32'h0000_1000);
    check("R4 line 7 not cleared by 0", {63'h0, rst_out[7]}, 64'h1);
    bus_read(CTRL0, 32'h0000_1080, "R8 ctrl0 shows line 7");
    bus_read(STAT0, 32'hFFFF_EF7F, "R7 stat0 shows line 7 low");
    idle(2 * PL);
    check("R4 idle line untouched", rst_out, 64'h0100_0000_0000_1000);

    // R5: second write of 1 does not extend the pulse
    bus_write(CTRL0, 32'h0000_1200);
    idle(4);
    bus_write(CTRL0, 32'h0000_1200);
    idle(PL - 6);
    check("R5 line 9 active before original end", {63'h0, rst_out[9]}, 64'h1);
    idle(1);
    check("R5 line 9 released at original time", {63'h0, rst_out[9]}, 64'h0);

    // R6 / R1: held line 56 and word-1 mapping
    bus_write(CTRL1, 32'h0000_0000);
    check("R6 line 56 cleared by 0", {63'h0, rst_out[56]}, 64'h0);
    bus_write(CTRL1, 32'h0000_0002);
    check("R1 ctrl1 bit 1 drives line 33", {63'h0, rst_out[33]}, 64'h1);
    idle(2 * PL);
    check("R6 line 56 stays clear", {63'h0, rst_out[56]}, 64'h0);
    bus_write(CTRL1, 32'h0100_0000);
    idle(2 * PL);
    check("R6 line 56 held set", {63'h0, rst_out[56]}, 64'h1);
    bus_write(CTRL0, 32'h0000_0000);
    check("R6 line 12 cleared by 0", {63'h0, rst_out[12]}, 64'h0);
    bus_read(CTRL0, 32'h0000_0000, "R8 ctrl0 all idle");

    // R9: system reset follows line 0
    bus_write(CTRL0, 32'h0000_0001);
    check("R9 sys reset asserted", {63'h0, sys_rst_out}, 64'h1);
    idle(PL - 1);
    check("R9 sys reset still active", {63'h0, sys_rst_out}, 64'h1);
    idle(1);
    check("R9 sys reset released", {63'h0, sys_rst_out}, 64'h0);

    // R11: unmapped writes and reads
    idle(PL);
    snap = rst_out;
    check("R11 quiet state", snap, 64'h0100_0000_0000_0000);
    bus_write(12'h108, 32'hFFFF_FFFF);
    bus_write(12'h14C, 32'hFFFF_FFFF);
    bus_write(STAT0, 32'hFFFF_FFFF);
    bus_write(12'h101, 32'hFFFF_FFFF);
    check("R11 unmapped writes ignored", rst_out, snap);
    bus_read(12'h200, 32'h0, "R11 unmapped read 0x200");
    bus_read(12'h158, 32'h0, "R11 unmapped read 0x158");

    // R7 / R6: read-modify-write through inverted status
    bus_read(STAT0, 32'hFFFF_FFFF, "R7 stat0 all inactive");
    bus_write(CTRL0, 32'h0000_1000);
    bus_read(STAT0, 32'hFFFF_EFFF, "R7 stat0 line 12 low");
    bus_write(CTRL0, ~32'hFFFF_EFFF | 32'h0010_0000);
    check("R6 line 12 kept by RMW", {63'h0, rst_out[12]}, 64'h1);
    check("R2 line 20 asserted by RMW", {63'h0, rst_out[20]}, 64'h1);

    idle(3);
    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: %0d reads never returned", sb_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule